// File: doc/BRIEF.md
# Single-Address Cycle-Steal DMA Channel

This block is one DMA channel that moves data from an external memory region straight to an external device. It works in single-address mode. The channel drives only the memory address, then raises a read strobe and a device acknowledge in the same bus cycle. The data travels on the external bus from memory to device and never passes through the channel.

Each request from the device moves exactly one unit, which is a byte, a word or a longword. Every unit costs one bus request and grant handshake and one 2-state read cycle. After each unit the channel hands the bus back for a programmed number of states, so that other masters can run their own cycles in that gap.

Software-side logic loads a start address, a unit count, a unit size, an increment flag and an end-strobe enable in one load pulse. The channel then counts the units down. When the count is used up, the channel disables itself. When the end-strobe enable is set, the last unit is marked with an end-of-transfer strobe.

Top module: `sa_dma_chan`

## Requirements
- R1: After reset, bus_req, rd_stb, ack_stb, end_stb and busy are all 0.
- R2: A request that is taken raises bus_req. While bus_gnt is 0, no strobe is driven and bus_req stays high. The read cycle starts in the cycle after the first clock edge that samples bus_gnt as 1.
- R3: A read cycle lasts exactly two clock states. Throughout it, rd_stb and ack_stb are both 1 and mem_addr holds the unit's address. bus_req stays high until the cycle ends.
- R4: With cfg_incr set, the address advances after each unit by the unit size. The cfg_size encodings are: 0 gives a byte and a step of 1, 1 gives a word and a step of 2, and 2 or 3 gives a longword and a step of 4.
- R5: With cfg_incr clear, every unit uses the start address.
- R6: After every unit, bus_req drops in the state that follows the read cycle, even when a further request is already pending.
- R7: A request sampled while a transfer or a release is in progress is held pending. bus_req rises again exactly REL_CYC+1 cycles after it dropped, which is REL_CYC release states plus one arbitration state, and the pending unit is then moved.
- R8: end_stb is 1 only during both states of the read cycle of the final unit, and only when cfg_end_en was set at load. In every other cycle it is 0.
- R9: After the unit count set at load has been moved, busy drops and further dreq pulses raise no bus_req. A load with a count of 0 leaves busy at 0.
- R10: A cfg_load pulse while busy is 1 is ignored. The running block keeps its address and its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load pulse for the block settings |
| cfg_addr | input | AW | Start memory address |
| cfg_count | input | CW | Number of units to move |
| cfg_size | input | 2 | Unit size: 0 byte, 1 word, 2 or 3 longword |
| cfg_incr | input | 1 | 1: the address advances by the unit size; 0: the address stays fixed |
| cfg_end_en | input | 1 | Enables end_stb on the final unit |
| dreq | input | 1 | Transfer request from the device, sampled on the rising edge |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | AW | Memory address during the read cycle, 0 otherwise |
| rd_stb | output | 1 | Memory read strobe |
| ack_stb | output | 1 | Device acknowledge strobe |
| end_stb | output | 1 | End-of-transfer strobe |
| busy | output | 1 | The channel is enabled and has units left |

## Verification
Two functions can fall in the same cycle: latching a new request and releasing the bus after the current unit. The bench raises dreq while a read cycle is still on the bus. It then checks that bus_req drops anyway and that the request is neither lost nor served early. The gap is judged by counting the states in which bus_req is low, and by checking that the following unit carries the next address. A second overlap, a load pulse that arrives during a running block, is judged by the address of the unit that comes next.

// File: rtl/sa_dma_chan.sv
module sa_dma_chan #(
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int REL_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_incr,
  input  logic          cfg_end_en,
  input  logic          dreq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          rd_stb,
  output logic          ack_stb,
  output logic          end_stb,
  output logic          busy
);

  localparam int RW = $clog2(REL_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_T1, S_T2, S_REL} state_t;

  state_t        st;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] remain;
  logic [1:0]    size_r;
  logic          incr_r, endo_r, en, pend;
  logic [RW-1:0] rel_cnt;
  logic [AW-1:0] step;
  logic          take, last, in_cyc;

  assign take   = (st == S_IDLE) && en && pend;
  assign last   = (remain == CW'(1));
  assign in_cyc = (st == S_T1) || (st == S_T2);
  assign step   = (size_r == 2'd0) ? AW'(1) : (size_r == 2'd1) ? AW'(2) : AW'(4);

  assign bus_req  = (st == S_REQ) || in_cyc;
  assign rd_stb   = in_cyc;
  assign ack_stb  = in_cyc;
  assign end_stb  = in_cyc && endo_r && last;
  assign mem_addr = in_cyc ? cur_addr : '0;
  assign busy     = en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      size_r   <= '0;
      incr_r   <= 1'b0;
      endo_r   <= 1'b0;
      en       <= 1'b0;
      pend     <= 1'b0;
      rel_cnt  <= '0;
    end else begin
      pend <= en && (dreq || (pend && !take));
      if (cfg_load && !en) begin
        cur_addr <= cfg_addr;
        remain   <= cfg_count;
        size_r   <= cfg_size;
        incr_r   <= cfg_incr;
        endo_r   <= cfg_end_en;
        en       <= (cfg_count != '0);
      end
      case (st)
        S_IDLE: if (take) st <= S_REQ;
        S_REQ:  if (bus_gnt) st <= S_T1;
        S_T1:   st <= S_T2;
        S_T2: begin
          st      <= S_REL;
          rel_cnt <= '0;
          remain  <= remain - CW'(1);
          if (incr_r) cur_addr <= cur_addr + step;
          if (last) en <= 1'b0;
        end
        S_REL: begin
          if (rel_cnt == RW'(REL_CYC - 1)) st <= S_IDLE;
          else rel_cnt <= rel_cnt + RW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sa_dma_chan_chk.sv
module sa_dma_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [AW-1:0] mem_addr,
  input logic          rd_stb,
  input logic          ack_stb,
  input logic          end_stb,
  input logic          busy
);

  a_r2_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_stb) |-> $past(bus_req && bus_gnt));

  a_r3_two_states: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_stb) |=> rd_stb);

  a_r3_no_third: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && $past(rd_stb)) |=> !rd_stb);

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && $past(rd_stb)) |-> $stable(mem_addr));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_stb) |-> !bus_req);

  a_r8_end_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    end_stb |-> (rd_stb && ack_stb));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !bus_req);

endmodule

bind sa_dma_chan sa_dma_chan_chk #(.AW(AW)) u_chk (.*);

// File: tb/sa_dma_chan_bench.sv
module sa_dma_chan_bench;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int REL_CYC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [1:0] cfg_size = '0;
  logic cfg_incr = 1'b0;
  logic cfg_end_en = 1'b0;
  logic dreq = 1'b0;
  logic bus_gnt = 1'b1;
  logic bus_req, rd_stb, ack_stb, end_stb, busy;
  logic [AW-1:0] mem_addr;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sa_dma_chan #(.AW(AW), .CW(CW), .REL_CYC(REL_CYC)) u_sa_dma_chan (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
    .cfg_count(cfg_count), .cfg_size(cfg_size), .cfg_incr(cfg_incr),
    .cfg_end_en(cfg_end_en), .dreq(dreq), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_addr(mem_addr), .rd_stb(rd_stb), .ack_stb(ack_stb), .end_stb(end_stb),
    .busy(busy)
  );

  // {addr[39:8], count[7:4], end_en[3], incr[2], size[1:0]}
  localparam logic [39:0] VEC [5] = '{
    {32'h0000_1000, 4'd3, 1'b1, 1'b1, 2'd0},
    {32'h0000_2000, 4'd3, 1'b1, 1'b1, 2'd1},
    {32'h0000_3000, 4'd2, 1'b0, 1'b1, 2'd2},
    {32'h0000_4000, 4'd3, 1'b1, 1'b0, 2'd0},
    {32'h0000_5000, 4'd2, 1'b1, 1'b1, 2'd3}
  };

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] a, input int n, input logic [1:0] sz, input bit inc, input bit ee);
    @(negedge clk);
    cfg_addr = a; cfg_count = CW'(n); cfg_size = sz; cfg_incr = inc; cfg_end_en = ee;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
  endtask

  task automatic wait_strobe(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (rd_stb) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic xfer(input logic [31:0] ea, input bit ee, input string r);
    bit seen;
    pulse_req();
    wait_strobe(seen);
    chk(seen, "R2 strobe after request", 32'(seen), 1);
    chk(mem_addr == ea, r, mem_addr, ea);
    chk(ack_stb == 1'b1, "R3 ack with read", 32'(ack_stb), 1);
    chk(end_stb == ee, "R8 end strobe state 1", 32'(end_stb), 32'(ee));
    @(negedge clk);
    chk(rd_stb && ack_stb && bus_req, "R3 second state", 32'(rd_stb), 1);
    chk(mem_addr == ea, "R3 address held", mem_addr, ea);
    chk(end_stb == ee, "R8 end strobe state 2", 32'(end_stb), 32'(ee));
    @(negedge clk);
    chk(!rd_stb && !bus_req, "R6 bus released", 32'(bus_req), 0);
    chk(!end_stb, "R8 end strobe off", 32'(end_stb), 0);
    repeat (REL_CYC + 1) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit seen;
    int lowc;
    repeat (3) @(negedge clk);
    chk(!bus_req && !rd_stb && !ack_stb && !end_stb && !busy, "R1 reset outputs", 32'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R4 increment, R5 fixed, R8 end strobe, R9 count
    foreach (VEC[k]) begin
      logic [31:0] a0 = VEC[k][39:8];
      int n = int'(VEC[k][7:4]);
      bit ee = VEC[k][3];
      bit inc = VEC[k][2];
      logic [1:0] sz = VEC[k][1:0];
      int stp = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      load(a0, n, sz, inc, ee);
      chk(busy, "R9 busy after load", 32'(busy), 1);
      for (int j = 0; j < n; j++)
        xfer(inc ? a0 + 32'(j * stp) : a0, ee && (j == n - 1), inc ? "R4 incremented address" : "R5 fixed address");
      chk(!busy, "R9 busy drops at count end", 32'(busy), 0);
      pulse_req();
      seen = 1'b0;
      repeat (8) begin @(negedge clk); if (bus_req) seen = 1'b1; end
      chk(!seen, "R9 request ignored when done", 32'(seen), 0);
    end

    // R9 zero count
    load(32'h600, 0, 2'd0, 1'b1, 1'b1);
    chk(!busy, "R9 zero count stays idle", 32'(busy), 0);

    // R2 wait for grant
    load(32'h700, 1, 2'd0, 1'b1, 1'b0);
    bus_gnt = 1'b0;
    pulse_req();
    repeat (5) @(negedge clk);
    chk(bus_req && !rd_stb, "R2 waits for grant", 32'(rd_stb), 0);
    bus_gnt = 1'b1;
    @(negedge clk);
    chk(rd_stb && mem_addr == 32'h700, "R2 cycle after grant", mem_addr, 32'h700);
    repeat (REL_CYC + 4) @(negedge clk);

    // R6/R7 request during a transfer
    load(32'h100, 3, 2'd0, 1'b1, 1'b0);
    pulse_req();
    wait_strobe(seen);
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
    @(negedge clk);
    chk(!bus_req, "R6 release with pending request", 32'(bus_req), 0);
    lowc = 0;
    while (!bus_req && lowc < 20) begin lowc++; @(negedge clk); end
    chk(lowc == REL_CYC + 1, "R7 release length", 32'(lowc), 32'(REL_CYC + 1));
    wait_strobe(seen);
    chk(seen && mem_addr == 32'h101, "R7 pending unit served", mem_addr, 32'h101);
    repeat (REL_CYC + 4) @(negedge clk);

    // R10 load while busy ignored
    load(32'h9000, 5, 2'd2, 1'b0, 1'b1);
    xfer(32'h102, 1'b0, "R10 load ignored while busy");
    chk(!busy, "R10 count kept", 32'(busy), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule